// File: doc/BRIEF.md
# Power amplifier ramp controller

This block produces the 6-bit level code that sets the drive current of a transmit power amplifier. When the amplifier is switched on, the code climbs one level at a time to a programmed target, so that the amplifier's changing load does not pull the oscillator and throw spurs around the carrier. The speed of the climb is chosen by a 3-bit rate field. Each rate is a number of code steps per data-bit period, and it is turned into a clock interval using a clocks-per-bit count given at an input.

There are two ways to switch the amplifier off. Clearing the amplifier enable makes the code ramp back down to zero at the same rate. Leaving transmit mode cuts the code to zero on the next clock. Rate setting 0 turns ramping off, and the code then jumps straight to its destination.

Top module: `pa_ramp_top`

## Requirements
- R1: A synchronous reset drives the level code to 0 and clears the step timer. After reset, isOff and settled are both high while the amplifier is disabled.
- R2: With rampSel equal to 0 and txMode high, a level code that differs from its destination takes the destination value on the next clock.
- R3: For rampSel values n from 1 to 7, the step interval in clocks is clksPerBit shifted right by (9 - n), with a minimum of one clock. The first step comes exactly one interval after a ramp starts, and each further step follows one interval after the last.
- R4: While txMode stays high and rampSel is not 0, the code changes by at most one level per clock.
- R5: With paEnable and txMode both high, the code ramps toward targetLevel, stops on it, and never passes it.
- R6: With txMode high and paEnable low, the code ramps down to 0 and then stays at 0.
- R7: When txMode is low, the code is 0 on the next clock, whatever the rate setting.
- R8: If targetLevel changes while the amplifier is enabled, the code ramps toward the new value, going up or down as needed.
- R9: settled is high exactly when the code equals its destination. The destination is targetLevel when paEnable and txMode are both high, and 0 otherwise. isOff is high exactly when the code is 0.
- R10: If paEnable falls during a ramp-up, the code turns around and ramps down from the level it has reached, without jumping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| targetLevel | input | 6 | Target amplifier level code |
| rampSel | input | 3 | Ramp rate select; 0 turns ramping off |
| paEnable | input | 1 | Amplifier enable; ramps in both directions |
| txMode | input | 1 | Transmit select; ramps up, cuts off hard |
| clksPerBit | input | 16 | Clock cycles in one data-bit period |
| levelCode | output | 6 | Current amplifier level code |
| settled | output | 1 | Code equals its destination |
| isOff | output | 1 | Code is zero |

## Verification
The bench looks for the boundary cases of the interval calculation. It checks the exact clock on which the first step lands and uses clksPerBit values small enough that the shifted count becomes 0. An off-by-one in the timer or a missing minimum clamp would show up as an early, late or stalled step. Directed sequences drop paEnable in the middle of a climb and drop txMode in the middle of a climb. A design that mixed up the two shutdown paths would either cut off when it should ramp down, or ramp when it should cut off. Random changes to the target, rate and enables are checked every cycle against a bench model, which catches overshoot, skipped levels and a wrong settled flag.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;
  localparam int RATE_SEL_W = 3;
  // rate n gives 2^(9-n) steps per bit, so its interval is clksPerBit >> (9-n)
  localparam int RATE_SHIFT_BASE = 9;

  typedef struct packed {
    logic clear;
    logic load;
    logic up;
    logic down;
  } ramp_cmd_t;
endpackage

// File: rtl/pa_ramp_ctrl.sv
module pa_ramp_ctrl
  import pa_ramp_pkg::*;
#(
  parameter int LEVEL_W = 6,
  parameter int CPB_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LEVEL_W-1:0]    targetLevel,
  input  logic [RATE_SEL_W-1:0] rampSel,
  input  logic                  paEnable,
  input  logic                  txMode,
  input  logic [CPB_W-1:0]      clksPerBit,
  input  logic [LEVEL_W-1:0]    levelCode,
  output logic [LEVEL_W-1:0]    destLevel,
  output ramp_cmd_t             cmd
);
  localparam int NUM_RATES = 1 << RATE_SEL_W;

  logic [CPB_W-1:0] intervalTab [NUM_RATES];
  logic [CPB_W-1:0] interval;
  logic [CPB_W-1:0] stepCnt;
  logic             atDest;
  logic             stepDue;

  for (genvar g = 0; g < NUM_RATES; g++) begin : gRate
    if (g == 0) begin : gNone
      assign intervalTab[g] = CPB_W'(1);
    end else begin : gShift
      logic [CPB_W-1:0] shifted;
      assign shifted        = clksPerBit >> (RATE_SHIFT_BASE - g);
      assign intervalTab[g] = (shifted == '0) ? CPB_W'(1) : shifted;
    end
  end

  assign interval = intervalTab[rampSel];

  always_comb begin
    destLevel = (paEnable && txMode) ? targetLevel : '0;
    atDest    = (levelCode == destLevel);
    stepDue   = (stepCnt >= interval - CPB_W'(1));
    cmd       = '0;
    if (!txMode) begin
      cmd.clear = 1'b1;
    end else if (!atDest) begin
      if (rampSel == '0) begin
        cmd.load = 1'b1;
      end else if (stepDue) begin
        if (levelCode < destLevel) cmd.up = 1'b1;
        else                       cmd.down = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !txMode || atDest || rampSel == '0 || stepDue) begin
      stepCnt <= '0;
    end else begin
      stepCnt <= stepCnt + CPB_W'(1);
    end
  end
endmodule

// File: rtl/pa_ramp_datapath.sv
module pa_ramp_datapath
  import pa_ramp_pkg::*;
#(
  parameter int LEVEL_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  ramp_cmd_t          cmd,
  input  logic [LEVEL_W-1:0] destLevel,
  output logic [LEVEL_W-1:0] levelCode,
  output logic               settled,
  output logic               isOff
);
  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      levelCode <= '0;
    end else if (cmd.load) begin
      levelCode <= destLevel;
    end else if (cmd.up) begin
      levelCode <= levelCode + LEVEL_W'(1);
    end else if (cmd.down) begin
      levelCode <= levelCode - LEVEL_W'(1);
    end
  end

  assign settled = (levelCode == destLevel);
  assign isOff   = (levelCode == '0);
endmodule

// File: rtl/pa_ramp_top.sv
module pa_ramp_top
  import pa_ramp_pkg::*;
#(
  parameter int LEVEL_W = 6,
  parameter int CPB_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LEVEL_W-1:0]    targetLevel,
  input  logic [RATE_SEL_W-1:0] rampSel,
  input  logic                  paEnable,
  input  logic                  txMode,
  input  logic [CPB_W-1:0]      clksPerBit,
  output logic [LEVEL_W-1:0]    levelCode,
  output logic                  settled,
  output logic                  isOff
);
  ramp_cmd_t          cmd;
  logic [LEVEL_W-1:0] destLevel;

  pa_ramp_ctrl #(.LEVEL_W(LEVEL_W), .CPB_W(CPB_W)) u_ctrl (
    .clk(clk), .rst(rst), .targetLevel(targetLevel), .rampSel(rampSel),
    .paEnable(paEnable), .txMode(txMode), .clksPerBit(clksPerBit),
    .levelCode(levelCode), .destLevel(destLevel), .cmd(cmd)
  );

  pa_ramp_datapath #(.LEVEL_W(LEVEL_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .destLevel(destLevel),
    .levelCode(levelCode), .settled(settled), .isOff(isOff)
  );
endmodule

// File: rtl/pa_ramp_checker.sv
module pa_ramp_checker #(
  parameter int LEVEL_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [LEVEL_W-1:0] targetLevel,
  input logic [2:0]         rampSel,
  input logic               paEnable,
  input logic               txMode,
  input logic [LEVEL_W-1:0] levelCode,
  input logic               settled,
  input logic               isOff
);
  logic [LEVEL_W:0] codeWide;
  assign codeWide = {1'b0, levelCode};

  p_hard_off_r7: assert property (@(posedge clk) disable iff (rst)
    !txMode |=> levelCode == '0);

  p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
    (txMode && rampSel != 3'd0) |=>
      (codeWide == $past(codeWide)) || (codeWide == $past(codeWide) + 1'b1) ||
      (codeWide + 1'b1 == $past(codeWide)));

  p_no_overshoot_r5: assert property (@(posedge clk) disable iff (rst)
    (paEnable && txMode && levelCode <= targetLevel) |=> levelCode <= $past(targetLevel));

  p_stay_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!paEnable && levelCode == '0) |=> levelCode == '0);

  p_settled_off_r9: assert property (@(posedge clk) disable iff (rst)
    (settled && !(paEnable && txMode)) |-> isOff);
endmodule

bind pa_ramp_top pa_ramp_checker #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rst(rst), .targetLevel(targetLevel), .rampSel(rampSel),
  .paEnable(paEnable), .txMode(txMode), .levelCode(levelCode),
  .settled(settled), .isOff(isOff)
);

// File: tb/tb_pa_ramp_top.sv
`timescale 1ns/1ps
module tb_pa_ramp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  targetLevel = '0;
  logic [2:0]  rampSel = '0;
  logic        paEnable = 1'b0;
  logic        txMode = 1'b0;
  logic [15:0] clksPerBit = 16'd64;
  logic [5:0]  levelCode;
  logic        settled;
  logic        isOff;

  int checks = 0;
  int errors = 0;
  int expCode = 0;
  int expCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pa_ramp_top dut (
    .clk(clk), .rst(rst), .targetLevel(targetLevel), .rampSel(rampSel),
    .paEnable(paEnable), .txMode(txMode), .clksPerBit(clksPerBit),
    .levelCode(levelCode), .settled(settled), .isOff(isOff)
  );

  function automatic int destOf();
    return (paEnable && txMode) ? int'(targetLevel) : 0;
  endfunction

  function automatic int intervalOf(int sel, int cpb);
    int v;
    v = cpb >> (9 - sel);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: update the bench model from the inputs at the edge, then compare
  task automatic tick();
    int d;
    @(posedge clk);
    d = destOf();
    if (rst || !txMode) begin
      expCode = 0; expCnt = 0;
    end else if (expCode == d) begin
      expCnt = 0;
    end else if (rampSel == 0) begin
      expCode = d; expCnt = 0;
    end else if (expCnt >= intervalOf(rampSel, clksPerBit) - 1) begin
      expCode += (expCode < d) ? 1 : -1; expCnt = 0;
    end else begin
      expCnt++;
    end
    #1;
    check("R4 code track", levelCode, expCode);
    check("R9 settled", settled, expCode == destOf());
    check("R9 isOff", isOff, expCode == 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    void'($urandom(32'd1234));
    ticks(3);
    check("R1 reset code", levelCode, 0);
    check("R1 reset isOff", isOff, 1);
    check("R1 reset settled", settled, 1);
    rst = 1'b0;
    txMode = 1'b1;
    ticks(2);

    // R2: no ramp, jump in one clock
    rampSel = 3'd0; targetLevel = 6'd37; paEnable = 1'b1;
    tick();
    check("R2 jump up", levelCode, 37);
    paEnable = 1'b0;
    tick();
    check("R2 jump down", levelCode, 0);

    // R3: clksPerBit 40, rate 5 -> interval 2
    clksPerBit = 16'd40; rampSel = 3'd5; targetLevel = 6'd10; paEnable = 1'b1;
    tick();
    check("R3 no step before interval", levelCode, 0);
    tick();
    check("R3 first step after interval", levelCode, 1);
    ticks(2);
    check("R3 second step", levelCode, 2);
    ticks(20);
    check("R5 reached target", levelCode, 10);
    check("R5 settled at target", settled, 1);
    ticks(6);
    check("R5 holds target", levelCode, 10);

    // R3: tiny count clamps to one clock
    paEnable = 1'b0; ticks(30);
    clksPerBit = 16'd3; rampSel = 3'd1; targetLevel = 6'd5; paEnable = 1'b1;
    tick();
    check("R3 clamp one clock", levelCode, 1);
    ticks(6);

    // R8: lower target while enabled
    targetLevel = 6'd2;
    tick();
    check("R8 ramps down to new target", levelCode, 4);
    ticks(4);
    check("R8 settles new target", levelCode, 2);

    // R10: disable mid ramp-up, then R6 to zero
    clksPerBit = 16'd8; rampSel = 3'd7; targetLevel = 6'd63;
    ticks(20);
    c = levelCode;
    paEnable = 1'b0;
    tick();
    check("R10 no jump on disable", (levelCode == c || levelCode == c - 1) ? 1 : 0, 1);
    ticks(2 * c + 4);
    check("R6 ramped down to zero", levelCode, 0);
    check("R6 off flag", isOff, 1);
    ticks(5);
    check("R6 stays zero", levelCode, 0);

    // R7: leave transmit mid ramp
    paEnable = 1'b1; targetLevel = 6'd40;
    ticks(24);
    check("R7 ramp under way", (levelCode > 0) ? 1 : 0, 1);
    txMode = 1'b0;
    tick();
    check("R7 hard off", levelCode, 0);
    txMode = 1'b1;
    ticks(3);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) targetLevel = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 5) == 0) rampSel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 4) == 0) paEnable = ~paEnable;
      txMode = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 9) == 0) clksPerBit = 16'($urandom_range(1, 300));
      ticks($urandom_range(1, 12));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule